// File: doc/BRIEF.md
# Configuration PROM CRC Verifier

This block checks the integrity of a configuration PROM made of 16-bit words. After a start pulse it reads the PROM one word at a time through a simple synchronous read port. It runs an 8-bit CRC over the contents, one byte per clock, and compares the result with the check byte kept in the top half of the final word. The final word's lower byte holds the layout revision, and the block reports it whatever the outcome of the check.

PROMs come in two layout sizes. The block first assumes the small layout. If that check fails and a fixed signature word sits at word 32, it reads the whole PROM again from address 0 as the large layout and checks it once more.

A single-cycle done pulse ends each verification. The pass flag, the layout that was chosen and the revision byte are registered when done pulses, and they hold their values until the next done pulse.

Top module: `prom_crc_verifier`

## Requirements
- R1: The CRC uses the reflected polynomial 0xAB (x^8 + x^7 + x^6 + x^4 + x^2 + 1) with a seed of 0xFF. Each byte is folded in least-significant bit first.
- R2: Every word except the last feeds its bits 7:0 and then its bits 15:8. The last word feeds only its bits 7:0. The running value is then XORed with 0xFF.
- R3: `crc_ok` is 1 when the final CRC equals bits 15:8 of the last word of the layout that was checked, and 0 otherwise.
- R4: `revision` carries bits 7:0 of the last word of the final layout checked, whether the check passed or failed.
- R5: The block falls back to the large layout when the small-layout check fails and word 32 equals 0x5372. It then re-reads from address 0 and sets `large_layout` to 1. If the large check also fails, `crc_ok` is 0 and `large_layout` stays 1.
- R6: There is no fallback when the small check passes, even if the signature is present, or when the small check fails and the signature is absent. In both cases `large_layout` is 0.
- R7: Reads go in ascending order from address 0 over the layout being checked, one read every two cycles. A pass with fallback reads SMALL_WORDS and then LARGE_WORDS words. `rd_data` must hold the addressed word in the cycle after `rd_en`.
- R8: `done` is a single-cycle pulse. Counting the clock edge that samples `start` as edge 0, it appears after edge 2N+1 for a single pass of N words, and after edge 2S+2L+2 when there is a fallback. The outputs change only together with `done`.
- R9: A `start` pulse while a verification is in progress is ignored. A `start` in the same cycle as `done` begins a new verification.
- R10: After reset, `done`, `crc_ok`, `large_layout`, `revision` and `rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a verification (accepted when idle) |
| rd_en | output | 1 | PROM word read request |
| rd_addr | output | ADDR_W | PROM word address |
| rd_data | input | 16 | PROM word, valid the cycle after rd_en |
| done | output | 1 | One-cycle end-of-verification pulse |
| crc_ok | output | 1 | Final CRC matched the stored check byte |
| large_layout | output | 1 | Large layout was used for the final check |
| revision | output | 8 | Low byte of the last word checked |

## Verification
Two events can land in the same cycle: the end of one verification, when `done` pulses and the block returns to idle, and a new `start`. The bench raises `start` in exactly the cycle that shows `done`. It then checks that a second run follows with the full latency, with the correct address sequence and with a second `done`. A second overlap is a `start` injected in the middle of a run. That case is judged by seeing exactly one `done`, an unchanged latency and no further reads after the run ends.

// File: rtl/promcrc_pkg.sv
package promcrc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_LO,
    S_HI,
    S_CMP
  } seq_state_t;

  localparam logic [7:0] CRC_SEED      = 8'hFF;
  localparam logic [7:0] CRC_REFL_POLY = 8'hAB;
  localparam logic [7:0] CRC_XOROUT    = 8'hFF;

  // one byte folded in, LSB first, reflected polynomial
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_REFL_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/promcrc_engine.sv
module promcrc_engine
  import promcrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       feed,
  input  logic [7:0] byte_in,
  output logic [7:0] crc_final
);
  logic [7:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      crc_q <= CRC_SEED;
    end else if (feed) begin
      crc_q <= crc8_step(crc_q, byte_in);
    end
  end

  assign crc_final = crc_q ^ CRC_XOROUT;

  // R1
  seed_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (crc_final == (CRC_SEED ^ CRC_XOROUT)));

  // R1
  clear_feed_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(clear && feed));
endmodule

// File: rtl/promcrc_seq.sv
module promcrc_seq
  import promcrc_pkg::*;
#(
  parameter int          SMALL_WORDS = 64,
  parameter int          LARGE_WORDS = 220,
  parameter int          SIG_INDEX   = 32,
  parameter logic [15:0] SIG_VALUE   = 16'h5372,
  parameter int          ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [15:0]       rd_data,
  output logic              crc_clear,
  output logic              crc_feed,
  output logic [7:0]        crc_byte,
  input  logic [7:0]        crc_final,
  output logic              finish,
  output logic              pass_ok,
  output logic              pass_large,
  output logic [7:0]        pass_rev
);
  localparam logic [ADDR_W-1:0] SMALL_LAST = ADDR_W'(SMALL_WORDS - 1);
  localparam logic [ADDR_W-1:0] LARGE_LAST = ADDR_W'(LARGE_WORDS - 1);
  localparam logic [ADDR_W-1:0] SIG_ADDR   = ADDR_W'(SIG_INDEX);

  seq_state_t        state_q;
  logic [ADDR_W-1:0] idx_q;
  logic [15:0]       word_q;
  logic              large_q;
  logic              sig_q;
  logic [ADDR_W-1:0] last_idx;
  logic              match;
  logic              fallback;

  assign last_idx = large_q ? LARGE_LAST : SMALL_LAST;
  assign match    = (crc_final == word_q[15:8]);
  assign fallback = (state_q == S_CMP) && !match && !large_q && sig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      word_q  <= '0;
      large_q <= 1'b0;
      sig_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (start) begin
            state_q <= S_REQ;
            idx_q   <= '0;
            large_q <= 1'b0;
            sig_q   <= 1'b0;
          end
        end
        S_REQ: state_q <= S_LO;
        S_LO: begin
          word_q <= rd_data;
          if (!large_q && idx_q == SIG_ADDR) begin
            sig_q <= (rd_data == SIG_VALUE);
          end
          state_q <= (idx_q == last_idx) ? S_CMP : S_HI;
        end
        S_HI: begin
          idx_q   <= idx_q + 1'b1;
          state_q <= S_LO;
        end
        S_CMP: begin
          if (fallback) begin
            large_q <= 1'b1;
            idx_q   <= '0;
            state_q <= S_REQ;
          end else begin
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_en     = (state_q == S_REQ) || (state_q == S_HI);
    rd_addr   = (state_q == S_HI) ? idx_q + 1'b1 : idx_q;
    crc_clear = (state_q == S_REQ);
    crc_feed  = (state_q == S_LO) || (state_q == S_HI);
    crc_byte  = (state_q == S_LO) ? rd_data[7:0] : word_q[15:8];
  end

  assign finish     = (state_q == S_CMP) && !fallback;
  assign pass_ok    = match;
  assign pass_large = large_q;
  assign pass_rev   = word_q[7:0];

  // R7
  addr_in_layout_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr <= last_idx));

  // R7
  read_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  // R5
  large_only_after_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(large_q) |-> $past(state_q == S_CMP));

  // R9
  start_ignored_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE && state_q != S_CMP && start) |=> !(state_q == S_REQ && idx_q == '0 && !large_q && $past(state_q) != S_IDLE && $past(state_q) != S_CMP));
endmodule

// File: rtl/promcrc_result.sv
module promcrc_result (
  input  logic       clk,
  input  logic       rst,
  input  logic       finish,
  input  logic       pass_ok,
  input  logic       pass_large,
  input  logic [7:0] pass_rev,
  output logic       done,
  output logic       crc_ok,
  output logic       large_layout,
  output logic [7:0] revision
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done         <= 1'b0;
      crc_ok       <= 1'b0;
      large_layout <= 1'b0;
      revision     <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        crc_ok       <= pass_ok;
        large_layout <= pass_large;
        revision     <= pass_rev;
      end
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  ok_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(crc_ok) |-> done);

  // R8
  rev_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(revision) |-> done);
endmodule

// File: rtl/prom_crc_verifier.sv
module prom_crc_verifier #(
  parameter int          SMALL_WORDS = 64,
  parameter int          LARGE_WORDS = 220,
  parameter int          SIG_INDEX   = 32,
  parameter logic [15:0] SIG_VALUE   = 16'h5372,
  parameter int          ADDR_W      = $clog2(LARGE_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [15:0]       rd_data,
  output logic              done,
  output logic              crc_ok,
  output logic              large_layout,
  output logic [7:0]        revision
);
  logic       crc_clear;
  logic       crc_feed;
  logic [7:0] crc_byte;
  logic [7:0] crc_final;
  logic       finish;
  logic       pass_ok;
  logic       pass_large;
  logic [7:0] pass_rev;

  promcrc_engine u_engine (
    .clk      (clk),
    .rst      (rst),
    .clear    (crc_clear),
    .feed     (crc_feed),
    .byte_in  (crc_byte),
    .crc_final(crc_final)
  );

  promcrc_seq #(
    .SMALL_WORDS(SMALL_WORDS),
    .LARGE_WORDS(LARGE_WORDS),
    .SIG_INDEX  (SIG_INDEX),
    .SIG_VALUE  (SIG_VALUE),
    .ADDR_W     (ADDR_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .crc_clear (crc_clear),
    .crc_feed  (crc_feed),
    .crc_byte  (crc_byte),
    .crc_final (crc_final),
    .finish    (finish),
    .pass_ok   (pass_ok),
    .pass_large(pass_large),
    .pass_rev  (pass_rev)
  );

  promcrc_result u_result (
    .clk         (clk),
    .rst         (rst),
    .finish      (finish),
    .pass_ok     (pass_ok),
    .pass_large  (pass_large),
    .pass_rev    (pass_rev),
    .done        (done),
    .crc_ok      (crc_ok),
    .large_layout(large_layout),
    .revision    (revision)
  );

  initial begin
    // R5
    sig_inside_small_chk: assert (SIG_INDEX < SMALL_WORDS && SMALL_WORDS < LARGE_WORDS);
  end

  // R9
  no_read_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_en);
endmodule

// File: tb/prom_crc_verifier_bench.sv
module prom_crc_verifier_bench;
  localparam int SW = 64;
  localparam int LW = 220;
  localparam int AW = $clog2(LW);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [15:0]   rd_data;
  logic          done;
  logic          crc_ok;
  logic          large_layout;
  logic [7:0]    revision;

  logic [15:0] mem [LW];
  int addr_log [1024];
  int nlog;
  int dones;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  prom_crc_verifier u_prom_crc_verifier (
    .clk(clk), .rst(rst), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .crc_ok(crc_ok),
    .large_layout(large_layout), .revision(revision)
  );

  // PROM model: synchronous word read
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  always @(negedge clk) begin
    if (rd_en && nlog < 1024) begin
      addr_log[nlog] = int'(rd_addr);
      nlog = nlog + 1;
    end
    if (done) dones = dones + 1;
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // serial-bit CRC model: feedback bit XORs in the reflected polynomial
  function automatic logic [7:0] ref_crc(input int n);
    logic [7:0] c;
    logic [7:0] b;
    logic fb;
    c = 8'hFF;
    for (int w = 0; w < n; w++) begin
      for (int h = 0; h < 2; h++) begin
        if (!(w == n - 1 && h == 1)) begin
          b = (h == 0) ? mem[w][7:0] : mem[w][15:8];
          for (int k = 0; k < 8; k++) begin
            fb = c[0] ^ b[k];
            c = c >> 1;
            if (fb) c = c ^ 8'hAB;
          end
        end
      end
    end
    return ~c;
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < LW; i++) begin
      mem[i] = 16'((i * 40503 + seed * 977 + 4660) ^ (i << 7) ^ (seed << 3));
    end
    if (mem[32] == 16'h5372) mem[32] = 16'h5373;
  endtask

  task automatic seal(input int n, input logic [7:0] rev, input bit good);
    logic [7:0] c;
    mem[n-1][7:0] = rev;
    c = ref_crc(n);
    mem[n-1][15:8] = good ? c : c ^ 8'h5A;
  endtask

  task automatic kick();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // counts edges after the accepted start edge until done is seen
  task automatic measure(input int inject_at, output int lat);
    int n;
    n = 0;
    lat = -1;
    while (n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = (n == inject_at);
      if (done) begin
        lat = n;
        break;
      end
    end
    start = 1'b0;
  endtask

  task automatic check_addrs(input string req, input int s, input int l);
    int bad;
    bad = 0;
    for (int i = 0; i < s; i++) if (addr_log[i] != i) bad++;
    for (int i = 0; i < l; i++) if (addr_log[s+i] != i) bad++;
    check(req, "read count", nlog, s + l);
    check(req, "address order errors", bad, 0);
  endtask

  task automatic run_one(input string req, input int inject_at, input int exp_lat,
                         input int exp_ok, input int exp_large, input int exp_rev,
                         input int s, input int l);
    int lat;
    nlog = 0;
    dones = 0;
    kick();
    measure(inject_at, lat);
    repeat (6) @(negedge clk);
    check(req, "latency", lat, exp_lat);
    check(req, "crc_ok", int'(crc_ok), exp_ok);
    check(req, "large_layout", int'(large_layout), exp_large);
    check(req, "revision", int'(revision), exp_rev);
    check("R8", "done pulses", dones, 1);
    check_addrs(req, s, l);
  endtask

  initial begin
    int lat;
    logic [7:0] c;
    while (cyc < 150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lat;
    for (int i = 0; i < LW; i++) mem[i] = '0;
    rd_data = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "done", int'(done), 0);
    check("R10", "crc_ok", int'(crc_ok), 0);
    check("R10", "rd_en", int'(rd_en), 0);
    check("R10", "revision", int'(revision), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4: valid small images, sweep of contents and revisions
    for (int s = 0; s < 12; s++) begin
      fill(s);
      seal(SW, 8'(s * 21 + 1), 1'b1);
      run_one("R3", 0, 2*SW+1, 1, 0, (s * 21 + 1) & 255, SW, 0);
    end

    // R2: every byte except the check byte is covered; flipping any one fails
    for (int p = 0; p < 8; p++) begin
      int w;
      int bit_pos;
      fill(100 + p);
      seal(SW, 8'h33, 1'b1);
      w = (p * 9) % (SW - 1);
      bit_pos = (p % 2 == 0) ? p : 8 + p;
      mem[w] = mem[w] ^ (16'h1 << bit_pos);
      if (mem[32] == 16'h5372) mem[32] = 16'h5370;
      run_one("R2", 0, 2*SW+1, 0, 0, 8'h33, SW, 0);
    end

    // R4: last word low byte feeds CRC; wrong revision byte fails but is reported
    fill(200);
    seal(SW, 8'h44, 1'b1);
    mem[SW-1][7:0] = 8'h45;
    run_one("R4", 0, 2*SW+1, 0, 0, 8'h45, SW, 0);

    // R6: small valid with signature present -> no fallback
    fill(201);
    mem[32] = 16'h5372;
    seal(SW, 8'h02, 1'b1);
    run_one("R6", 0, 2*SW+1, 1, 0, 8'h02, SW, 0);

    // R6: small invalid, signature absent -> fail, small
    fill(202);
    seal(SW, 8'h03, 1'b0);
    run_one("R6", 0, 2*SW+1, 0, 0, 8'h03, SW, 0);

    // R5: small fails, signature present, large valid
    for (int s = 0; s < 3; s++) begin
      fill(300 + s);
      mem[32] = 16'h5372;
      seal(SW, 8'h01, 1'b0);
      seal(LW, 8'(4 + s), 1'b1);
      begin
        logic [7:0] cs;
        cs = ref_crc(SW);
        if (mem[SW-1][15:8] == cs) mem[SW-1][15:8] = cs ^ 8'h01;
      end
      seal(LW, 8'(4 + s), 1'b1);
      run_one("R5", 0, 2*SW+2*LW+2, 1, 1, 4 + s, SW, LW);
    end

    // R5: fallback and the large check fails too
    fill(310);
    mem[32] = 16'h5372;
    seal(SW, 8'h01, 1'b0);
    seal(LW, 8'h09, 1'b0);
    run_one("R5", 0, 2*SW+2*LW+2, 0, 1, 8'h09, SW, LW);

    // R9: start injected mid-run is ignored
    fill(400);
    seal(SW, 8'h77, 1'b1);
    run_one("R9", 40, 2*SW+1, 1, 0, 8'h77, SW, 0);

    // R9: start in the done cycle starts a second run at once
    fill(401);
    seal(SW, 8'h66, 1'b1);
    nlog = 0;
    dones = 0;
    kick();
    measure(0, lat);
    check("R8", "first latency", lat, 2*SW+1);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    measure(0, lat);
    repeat (4) @(negedge clk);
    check("R9", "back-to-back latency", lat, 2*SW+1);
    check("R9", "back-to-back done pulses", dones, 2);
    check("R9", "back-to-back reads", nlog, 2*SW);
    check("R9", "second crc_ok", int'(crc_ok), 1);

    // R8: outputs hold between runs; no reads while idle
    nlog = 0;
    repeat (20) @(negedge clk);
    check("R8", "idle reads", nlog, 0);
    check("R8", "held revision", int'(revision), 8'h66);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule